// File: doc/BRIEF.md
# Systolic Matrix Engine with Carry-Recomposing Bottom Row

This block is a square, weight-stationary systolic array of 8-bit multiply-accumulate cells. A host preloads one 8-bit weight into every cell, one row per cycle. It then streams activation vectors into the left edge, skewed by one cycle per row. Activations travel right through the array and partial sums travel down. The bottom row closes each column's sum.

In plain mode the block is an ordinary unsigned integer matrix multiplier. Each column returns its full-width dot product.

In multi-precision mode the host has split wide operands into base-256 digits. The digits of one operand go into the weights in a shifted, Toeplitz layout, so each output column collects the cross products of one digit weight. The bottom-row cells add a carry that arrives from the neighbouring lower-weight column and keep the low byte as the digit. The remaining upper bits pass to the next column, one cycle later, which is the same cycle that column's own sum arrives. A per-column mask marks where a digit group starts, and carries never cross that boundary. The top column of a group also exposes its outgoing carry, so the recomposed product leaves the array complete. It needs no shift-and-add pass afterwards and no stall.

Top module: `recon_systolic_array`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every `resultOut` and `carryOut` lane reads zero.
- R2: In plain mode (`multiMode`=0), column j returns sum over rows i of act[i]*W[i][j], unsigned. Row i of activation vector t is presented on `actIn[i]` in cycle t+i. The result for column j appears on `resultOut[j]` from cycle t+N+j on.
- R3: The column sum is 16+log2(N) bits wide and never wraps. With all weights and activations at 255 and N=8, every column returns 520200.
- R4: A new activation vector is accepted every cycle in both modes with no stall. Back-to-back vectors give back-to-back results.
- R5: In multi-precision mode, `resultOut[j]` carries the low 8 bits of (column sum + accepted incoming carry), zero-extended, so it is always below 256.
- R6: In multi-precision mode, `carryOut[j]` equals (column sum + accepted incoming carry) shifted right by 8. Column j+1 adds this value to the sum of the same activation vector.
- R7: A column whose `groupStart` bit is 1, and column 0 always, treats its incoming carry as zero.
- R8: In plain mode every `carryOut` lane is zero and no carry enters any column.
- R9: With a Toeplitz weight layout, the digits of a group plus the top column's carry shifted above them equal the exact wide product. This holds for 16-bit by 16-bit groups (three columns) and for 32-bit by 32-bit groups (seven columns).
- R10: A weight load writes only the row addressed by `loadRow`, using `loadData[j]` for column j. All other weights hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Write one weight row this cycle |
| loadRow | input | log2(N) | Row written by a load |
| loadData | input | N x 8 | Weights for the addressed row, one byte per column |
| actIn | input | N x 8 | Skewed activations, one byte per row |
| multiMode | input | 1 | 1 = digit recomposition, 0 = plain matrix multiply |
| groupStart | input | N | Bit j set: column j begins a digit group |
| resultOut | output | N x (16+log2 N) | Column sum (plain) or recomposed digit (multi) |
| carryOut | output | N x (9+log2 N) | Outgoing carry of each column (multi), zero in plain mode |

## Verification
A column-j result for the vector whose row-0 byte entered in cycle t is due on the edge that ends cycle t+N-1+j. It is read in cycle t+N+j, and the carry that column j hands on is visible in that same cycle. The bench drives the skew itself, one cycle per row. It samples every lane on the falling edge and files each value under the vector index t = k-N+1-j, where k is the sampling step. Each recorded value is therefore compared only with the vector it belongs to. A weight load takes effect on the edge that ends its cycle, so every run starts only after the load has settled.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  localparam int DIGIT_W = 8;

  typedef struct packed {
    logic multiMode;
    logic loadActive;
  } strobe_t;
endpackage

// File: rtl/rsa_ctrl.sv
module rsa_ctrl
  import rsa_pkg::*;
#(
  parameter int N  = 8,
  parameter int RW = 3
) (
  input  logic          loadEn,
  input  logic [RW-1:0] loadRow,
  input  logic          multiModeIn,
  input  logic [N-1:0]  groupStart,
  output strobe_t       strobes,
  output logic [N-1:0]  rowSel,
  output logic [N-1:0]  carryKeep
);
  always_comb begin
    strobes.multiMode  = multiModeIn;
    strobes.loadActive = loadEn;
    for (int i = 0; i < N; i++) begin
      rowSel[i]    = (loadRow == RW'(i));
      // column 0 has no lower neighbour; a group start cuts the chain (R7, R8)
      carryKeep[i] = multiModeIn && !groupStart[i] && (i != 0);
    end
  end
endmodule

// File: rtl/rsa_mac_cell.sv
module rsa_mac_cell #(
  parameter int SW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          weightWe,
  input  logic [7:0]    weightIn,
  input  logic [7:0]    act,
  input  logic [SW-1:0] psumIn,
  output logic [SW-1:0] psumOut
);
  logic [7:0]  weight;
  logic [15:0] prod;

  always_comb prod = 16'(act) * 16'(weight);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weight  <= '0;
      psumOut <= '0;
    end else begin
      if (weightWe) weight <= weightIn;
      psumOut <= psumIn + SW'(prod);
    end
  end

  assert_weight_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !weightWe |=> $stable(weight));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (psumOut >= $past(psumIn)));
endmodule

// File: rtl/rsa_recon_cell.sv
module rsa_recon_cell #(
  parameter int SW = 19,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          weightWe,
  input  logic [7:0]    weightIn,
  input  logic [7:0]    act,
  input  logic [SW-1:0] psumIn,
  input  logic          multiMode,
  input  logic          carryKeep,
  input  logic [CW-1:0] carryIn,
  output logic [SW-1:0] resultOut,
  output logic [CW-1:0] carryOut
);
  logic [7:0]    weight;
  logic [15:0]   prod;
  logic [SW-1:0] colSum;
  logic [CW-1:0] carryEff;
  logic [SW:0]   total;

  always_comb begin
    prod     = 16'(act) * 16'(weight);
    colSum   = psumIn + SW'(prod);
    carryEff = carryKeep ? carryIn : '0;
    total    = (SW+1)'(colSum) + (SW+1)'(carryEff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weight    <= '0;
      resultOut <= '0;
      carryOut  <= '0;
    end else begin
      if (weightWe) weight <= weightIn;
      if (multiMode) begin
        resultOut <= SW'(total[7:0]);
        carryOut  <= total[SW:8];
      end else begin
        resultOut <= colSum;
        carryOut  <= '0;
      end
    end
  end

  assert_weight_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !weightWe |=> $stable(weight));

  assert_digit_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    multiMode |=> (resultOut < SW'(256)));

  assert_plain_no_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !multiMode |=> (carryOut == '0));
endmodule

// File: rtl/rsa_datapath.sv
module rsa_datapath
  import rsa_pkg::*;
#(
  parameter int N  = 8,
  parameter int SW = 19,
  parameter int CW = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               strobes,
  input  logic [N-1:0]          rowSel,
  input  logic [N-1:0]          carryKeep,
  input  logic [N-1:0][7:0]     loadData,
  input  logic [N-1:0][7:0]     actIn,
  output logic [N-1:0][SW-1:0]  resultOut,
  output logic [N-1:0][CW-1:0]  carryOut
);
  logic [7:0]    actAt  [N][N];
  logic [SW-1:0] psumAt [N][N];
  logic [CW-1:0] carryIn [N];

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (j == 0) begin : g_edge
        assign actAt[i][0] = actIn[i];
      end else begin : g_hop
        logic [7:0] actQ;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) actQ <= '0;
          else        actQ <= actAt[i][j-1];
        end
        assign actAt[i][j] = actQ;
      end

      if (i == 0) begin : g_top
        assign psumAt[0][j] = '0;
      end

      if (i < N-1) begin : g_mac
        rsa_mac_cell #(.SW(SW)) u_cell (
          .clk(clk), .rst_n(rst_n),
          .weightWe(strobes.loadActive & rowSel[i]),
          .weightIn(loadData[j]), .act(actAt[i][j]),
          .psumIn(psumAt[i][j]), .psumOut(psumAt[i+1][j])
        );
      end else begin : g_recon
        rsa_recon_cell #(.SW(SW), .CW(CW)) u_cell (
          .clk(clk), .rst_n(rst_n),
          .weightWe(strobes.loadActive & rowSel[i]),
          .weightIn(loadData[j]), .act(actAt[i][j]),
          .psumIn(psumAt[i][j]), .multiMode(strobes.multiMode),
          .carryKeep(carryKeep[j]), .carryIn(carryIn[j]),
          .resultOut(resultOut[j]), .carryOut(carryOut[j])
        );
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_chain
    if (j == 0) begin : g_first
      assign carryIn[0] = '0;
    end else begin : g_link
      assign carryIn[j] = carryOut[j-1];
    end
  end
endmodule

// File: rtl/recon_systolic_array.sv
module recon_systolic_array
  import rsa_pkg::*;
#(
  parameter int N = 8,
  localparam int SW = 16 + $clog2(N),
  localparam int CW = SW - 7,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 loadEn,
  input  logic [RW-1:0]        loadRow,
  input  logic [N-1:0][7:0]    loadData,
  input  logic [N-1:0][7:0]    actIn,
  input  logic                 multiMode,
  input  logic [N-1:0]         groupStart,
  output logic [N-1:0][SW-1:0] resultOut,
  output logic [N-1:0][CW-1:0] carryOut
);
  strobe_t      strobes;
  logic [N-1:0] rowSel;
  logic [N-1:0] carryKeep;

  rsa_ctrl #(.N(N), .RW(RW)) u_ctrl (
    .loadEn(loadEn), .loadRow(loadRow), .multiModeIn(multiMode),
    .groupStart(groupStart), .strobes(strobes), .rowSel(rowSel),
    .carryKeep(carryKeep)
  );

  rsa_datapath #(.N(N), .SW(SW), .CW(CW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .rowSel(rowSel),
    .carryKeep(carryKeep), .loadData(loadData), .actIn(actIn),
    .resultOut(resultOut), .carryOut(carryOut)
  );
endmodule

// File: tb/recon_systolic_array_test.sv
`timescale 1ns/1ps
module recon_systolic_array_test;
  localparam int N = 8;
  localparam int SW = 19;
  localparam int CW = 12;
  localparam int MAXV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadEn = 1'b0;
  logic [2:0] loadRow = '0;
  logic [N-1:0][7:0] loadData = '0;
  logic [N-1:0][7:0] actIn = '0;
  logic multiMode = 1'b0;
  logic [N-1:0] groupStart = '0;
  logic [N-1:0][SW-1:0] resultOut;
  logic [N-1:0][CW-1:0] carryOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] wMat [N][N];
  logic [7:0] vecA [MAXV][N];
  int nv;
  logic [SW-1:0] resCap [MAXV][N];
  logic [CW-1:0] carCap [MAXV][N];

  recon_systolic_array #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadRow(loadRow),
    .loadData(loadData), .actIn(actIn), .multiMode(multiMode),
    .groupStart(groupStart), .resultOut(resultOut), .carryOut(carryOut)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearWeights();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wMat[r][c] = 8'd0;
  endtask

  task automatic loadRowOnly(input int r);
    loadEn = 1'b1;
    loadRow = 3'(r);
    for (int c = 0; c < N; c++) loadData[c] = wMat[r][c];
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic loadAll();
    for (int r = 0; r < N; r++) loadRowOnly(r);
  endtask

  task automatic runVectors();
    for (int k = 0; k < nv + 2*N; k++) begin
      for (int i = 0; i < N; i++) begin
        int t;
        t = k - i;
        actIn[i] = (t >= 0 && t < nv) ? vecA[t][i] : 8'd0;
      end
      @(posedge clk);
      @(negedge clk);
      for (int j = 0; j < N; j++) begin
        int t;
        t = k - N + 1 - j;
        if (t >= 0 && t < nv) begin
          resCap[t][j] = resultOut[j];
          carCap[t][j] = carryOut[j];
        end
      end
    end
  endtask

  task automatic expectPlain(input string tag);
    for (int t = 0; t < nv; t++)
      for (int j = 0; j < N; j++) begin
        longint e;
        e = 0;
        for (int i = 0; i < N; i++) e += longint'(vecA[t][i]) * longint'(wMat[i][j]);
        check(resCap[t][j] == SW'(e), tag, longint'(resCap[t][j]), e);
        check(carCap[t][j] == '0, "R8 plain carry zero", longint'(carCap[t][j]), 0);
      end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    for (int j = 0; j < N; j++) begin
      check(resultOut[j] == '0, "R1 result in reset", longint'(resultOut[j]), 0);
      check(carryOut[j] == '0, "R1 carry in reset", longint'(carryOut[j]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int j = 0; j < N; j++)
      check(resultOut[j] == '0, "R1 result after reset", longint'(resultOut[j]), 0);
  endtask

  task automatic testPlainRandom();
    multiMode = 1'b0;
    groupStart = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wMat[r][c] = 8'($urandom);
    loadAll();
    nv = 10;
    for (int t = 0; t < nv; t++)
      for (int i = 0; i < N; i++) vecA[t][i] = 8'($urandom);
    runVectors();
    expectPlain("R2 R4 back-to-back matmul");
  endtask

  task automatic testPlainMax();
    multiMode = 1'b0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wMat[r][c] = 8'hFF;
    loadAll();
    nv = 3;
    for (int t = 0; t < nv; t++)
      for (int i = 0; i < N; i++) vecA[t][i] = 8'hFF;
    runVectors();
    for (int j = 0; j < N; j++)
      check(resCap[1][j] == SW'(520200), "R3 full-scale column", longint'(resCap[1][j]), 520200);
  endtask

  task automatic testWeightHold();
    multiMode = 1'b0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wMat[r][c] = 8'($urandom);
    loadAll();
    for (int c = 0; c < N; c++) wMat[3][c] = 8'(c + 1);
    loadRowOnly(3);
    nv = 6;
    for (int t = 0; t < nv; t++)
      for (int i = 0; i < N; i++) vecA[t][i] = 8'($urandom);
    runVectors();
    expectPlain("R10 single row reload");
  endtask

  task automatic testMulti16();
    logic [15:0] bLo, bHi;
    logic [15:0] aLo [MAXV];
    logic [15:0] aHi [MAXV];
    multiMode = 1'b1;
    groupStart = 8'b1100_1001;
    bLo = 16'hFFFF;
    bHi = 16'($urandom);
    clearWeights();
    for (int r = 0; r < 2; r++)
      for (int d = 0; d < 2; d++) begin
        wMat[r][r+d]     = bLo[8*d +: 8];
        wMat[2+r][3+r+d] = bHi[8*d +: 8];
      end
    loadAll();
    nv = 8;
    for (int t = 0; t < nv; t++) begin
      aLo[t] = (t == 0) ? 16'hFFFF : 16'($urandom);
      aHi[t] = 16'($urandom);
      for (int i = 0; i < N; i++) vecA[t][i] = 8'($urandom);
      vecA[t][0] = aLo[t][7:0];
      vecA[t][1] = aLo[t][15:8];
      vecA[t][2] = aHi[t][7:0];
      vecA[t][3] = aHi[t][15:8];
    end
    runVectors();
    for (int t = 0; t < nv; t++)
      for (int g = 0; g < 2; g++) begin
        longint unsigned p, rebuilt;
        int base;
        base = 3 * g;
        p = (g == 0) ? longint'(aLo[t]) * longint'(bLo) : longint'(aHi[t]) * longint'(bHi);
        rebuilt = 0;
        for (int d = 0; d < 3; d++) begin
          rebuilt |= longint'(resCap[t][base+d][7:0]) << (8*d);
          check(resCap[t][base+d] == SW'((p >> (8*d)) & 255), "R5 16-bit digit",
                longint'(resCap[t][base+d]), longint'((p >> (8*d)) & 255));
        end
        check(carCap[t][base+2] == CW'(p >> 24), "R6 16-bit top carry",
              longint'(carCap[t][base+2]), longint'(p >> 24));
        rebuilt += longint'(carCap[t][base+2]) << 24;
        check(rebuilt == p, "R9 16-bit product", longint'(rebuilt), longint'(p));
      end
  endtask

  task automatic testMulti32();
    logic [31:0] b;
    logic [31:0] a [MAXV];
    multiMode = 1'b1;
    groupStart = 8'b1000_0001;
    b = 32'($urandom) | 32'hFF00_0000;
    clearWeights();
    for (int r = 0; r < 4; r++)
      for (int d = 0; d < 4; d++) wMat[r][r+d] = b[8*d +: 8];
    loadAll();
    nv = 8;
    for (int t = 0; t < nv; t++) begin
      a[t] = (t == 0) ? 32'hFFFF_FFFF : 32'($urandom);
      for (int i = 0; i < N; i++) vecA[t][i] = 8'($urandom);
      for (int i = 0; i < 4; i++) vecA[t][i] = a[t][8*i +: 8];
    end
    runVectors();
    for (int t = 0; t < nv; t++) begin
      longint unsigned p, rebuilt, run;
      p = longint'(a[t]) * longint'(b);
      rebuilt = 0;
      run = 0;
      for (int k = 0; k < 7; k++) begin
        longint unsigned cs;
        cs = 0;
        for (int r = 0; r < 4; r++)
          if (k - r >= 0 && k - r < 4)
            cs += longint'(vecA[t][r]) * longint'(wMat[r][k]);
        run = run + cs;
        check(carCap[t][k] == CW'(run >> 8), "R6 column carry",
              longint'(carCap[t][k]), longint'(run >> 8));
        run = run >> 8;
        rebuilt |= longint'(resCap[t][k][7:0]) << (8*k);
      end
      rebuilt += longint'(carCap[t][6]) << 56;
      check(rebuilt == p, "R9 32-bit product", longint'(rebuilt), longint'(p));
    end
  endtask

  task automatic testIsolate();
    multiMode = 1'b1;
    clearWeights();
    for (int r = 0; r < 4; r++) wMat[r][2] = 8'hFF;
    loadAll();
    nv = 2;
    for (int t = 0; t < nv; t++)
      for (int i = 0; i < N; i++) vecA[t][i] = (i < 4) ? 8'hFF : 8'h00;
    groupStart = 8'b0000_0101;
    runVectors();
    check(resCap[1][2] == SW'(4), "R5 source digit", longint'(resCap[1][2]), 4);
    check(carCap[1][2] == CW'(1016), "R6 source carry", longint'(carCap[1][2]), 1016);
    check(resCap[1][3] == SW'(248), "R7 carry accepted digit", longint'(resCap[1][3]), 248);
    check(carCap[1][3] == CW'(3), "R7 carry accepted high", longint'(carCap[1][3]), 3);
    groupStart = 8'b0000_1101;
    runVectors();
    check(resCap[1][3] == '0, "R7 blocked carry digit", longint'(resCap[1][3]), 0);
    check(carCap[1][3] == '0, "R7 blocked carry high", longint'(carCap[1][3]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testPlainRandom();
    testPlainMax();
    testWeightHold();
    testMulti16();
    testMulti32();
    testIsolate();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule